// File: doc/BRIEF.md
# Boundary-Scan Test Port with Instruction Decode

This block is a standard sixteen-state test access port controller with an eight-bit instruction register. Its current instruction picks the serial register that sits between `tdi` and `tdo` and drives the pin-control flags of the chip. The bypass bit, the identification register, the user-code register, a 10-bit address register and an 89-bit column register are all inside the block. The boundary-scan cells live outside it. They receive capture, shift and update strobes, and their serial output comes back on `bsr_so`.

Instructions that work on non-volatile memory are not carried out here. The block recognises them, publishes the current code and gives a strobe for every cycle spent in Run-Test/Idle, so the logic that owns the memory can act on them. One code produces a single-cycle reset pulse for the user logic. Every unassigned code, and every code with its top bit set, connects the bypass bit, so a chain of devices never breaks.

Top module: `jtag_tap_decode`

## Requirements
- R1: Asserting `trst_n` low, or holding `tms` high long enough to reach Test-Logic-Reset, sets the instruction to 0x16. A data scan right after reset therefore returns the identification value. A new instruction takes effect only on the Update-IR edge.
- R2: In Capture-IR the instruction shift register loads 0b00000001. It then shifts out LSB first while `tdi` fills it from the top.
- R3: A code with bit 7 set selects the one-bit bypass register, which captures 0. No pin-control flag is raised.
- R4: Code 0x16 selects a 32-bit register that captures the `ID_CODE` parameter. Code 0x17 selects a 32-bit register that captures `USER_CODE`.
- R5: Code 0x01 selects a 10-bit address register and code 0x02 an 89-bit column register. Capture leaves both unchanged, so a second scan returns what the first scan shifted in.
- R6: Codes 0x00 and 0x1C route `bsr_so` to `tdo` and assert `bsr_capture`, `bsr_shift` and `bsr_update` in Capture-DR, Shift-DR and Update-DR. `bsr_drive` is high while the code is 0x00 or 0x20, and 0x20 selects bypass.
- R7: Code 0x18 raises `pins_hiz` and selects bypass.
- R8: Loading code 0x22 makes `user_rst` high for exactly the one cycle that follows the Update-IR edge.
- R9: For the memory codes 0x03, 0x07, 0x09, 0x0A, 0x14, 0x15, 0x1A, 0x1E, 0x24, 0x27, 0x2A and 0x2F, `nv_strobe` is high in every Run-Test/Idle cycle and bypass is selected. `nv_code` always shows the current instruction.
- R10: Any other code with bit 7 clear selects bypass and raises no flag.
- R11: `tdo` changes only on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_drive | output | 1 | Pins driven from boundary cells |
| pins_hiz | output | 1 | Force all outputs high impedance |
| user_rst | output | 1 | One-cycle user logic reset |
| nv_strobe | output | 1 | Memory-operation strobe in Run-Test/Idle |
| nv_code | output | IR_W | Current instruction code |

## Verification
A new instruction is shifted in while the previous one still drives the pins. Pin controls such as `pins_hiz` from an earlier HIGHZ code must therefore stay asserted through Capture-IR and Shift-IR and drop only on the Update-IR edge. In the same way, the Update-IR edge that loads 0x22 must produce the reset pulse and the new decode in the same cycle. The bench provokes this by loading HIGHZ, EXTEST and the reset code back to back. A behavioural model then judges every flag and `tdo` on every clock, and also confirms that `tdo` never moves on a rising edge.

// File: rtl/jtag_tap_decode.sv
module jtag_tap_decode #(
  parameter int          IR_W      = 8,
  parameter int          ADDR_W    = 10,
  parameter int          COL_W     = 89,
  parameter int          ID_W      = 32,
  parameter logic [31:0] ID_CODE   = 32'h1A5C_0043,
  parameter logic [31:0] USER_CODE = 32'h0000_0000
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic            bsr_so,
  output logic            tdo,
  output logic            tdo_en,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            bsr_drive,
  output logic            pins_hiz,
  output logic            user_rst,
  output logic            nv_strobe,
  output logic [IR_W-1:0] nv_code
);

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UP_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UP_IR
  } tap_st_e;

  typedef enum logic [2:0] {D_BYP, D_BSR, D_ID, D_USR, D_ADR, D_COL} dsel_e;

  localparam logic [IR_W-1:0] C_EXTEST = IR_W'('h00);
  localparam logic [IR_W-1:0] C_ADDR   = IR_W'('h01);
  localparam logic [IR_W-1:0] C_COL    = IR_W'('h02);
  localparam logic [IR_W-1:0] C_IDC    = IR_W'('h16);
  localparam logic [IR_W-1:0] C_USR    = IR_W'('h17);
  localparam logic [IR_W-1:0] C_HIZ    = IR_W'('h18);
  localparam logic [IR_W-1:0] C_SAMP   = IR_W'('h1C);
  localparam logic [IR_W-1:0] C_CLAMP  = IR_W'('h20);
  localparam logic [IR_W-1:0] C_URST   = IR_W'('h22);
  localparam logic [IR_W-1:0] C_CAPIR  = IR_W'(2'b01);

  tap_st_e           state, state_nx;
  dsel_e             dsel;
  logic [IR_W-1:0]   ir, ir_sr;
  logic              byp_q, urst_q, tdo_q, tdo_en_q, dr_lsb, is_nv;
  logic [ID_W-1:0]   id_sr, usr_sr;
  logic [ADDR_W-1:0] adr_sr;
  logic [COL_W-1:0]  col_sr;

  always_comb begin
    case (state)
      TLR:     state_nx = tms ? TLR    : RTI;
      RTI:     state_nx = tms ? SEL_DR : RTI;
      SEL_DR:  state_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR:  state_nx = tms ? EX1_DR : SH_DR;
      SH_DR:   state_nx = tms ? EX1_DR : SH_DR;
      EX1_DR:  state_nx = tms ? UP_DR  : PA_DR;
      PA_DR:   state_nx = tms ? EX2_DR : PA_DR;
      EX2_DR:  state_nx = tms ? UP_DR  : SH_DR;
      UP_DR:   state_nx = tms ? SEL_DR : RTI;
      SEL_IR:  state_nx = tms ? TLR    : CAP_IR;
      CAP_IR:  state_nx = tms ? EX1_IR : SH_IR;
      SH_IR:   state_nx = tms ? EX1_IR : SH_IR;
      EX1_IR:  state_nx = tms ? UP_IR  : PA_IR;
      PA_IR:   state_nx = tms ? EX2_IR : PA_IR;
      EX2_IR:  state_nx = tms ? UP_IR  : SH_IR;
      default: state_nx = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= TLR;
    else         state <= state_nx;

  always_comb begin
    dsel = D_BYP;
    if (!ir[IR_W-1]) begin
      case (ir)
        C_EXTEST, C_SAMP: dsel = D_BSR;
        C_IDC:            dsel = D_ID;
        C_USR:            dsel = D_USR;
        C_ADDR:           dsel = D_ADR;
        C_COL:            dsel = D_COL;
        default:          dsel = D_BYP;
      endcase
    end
  end

  always_comb begin
    case (ir)
      IR_W'('h03), IR_W'('h07), IR_W'('h09), IR_W'('h0A),
      IR_W'('h14), IR_W'('h15), IR_W'('h1A), IR_W'('h1E),
      IR_W'('h24), IR_W'('h27), IR_W'('h2A), IR_W'('h2F): is_nv = 1'b1;
      default: is_nv = 1'b0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir     <= C_IDC;
      ir_sr  <= '0;
      urst_q <= 1'b0;
    end else begin
      urst_q <= (state == UP_IR) && (ir_sr == C_URST);
      case (state)
        TLR:    ir    <= C_IDC;
        CAP_IR: ir_sr <= C_CAPIR;
        SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UP_IR:  ir    <= ir_sr;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      usr_sr <= '0;
      adr_sr <= '0;
      col_sr <= '0;
    end else if (state == CAP_DR) begin
      case (dsel)
        D_BYP:   byp_q  <= 1'b0;
        D_ID:    id_sr  <= ID_CODE[ID_W-1:0];
        D_USR:   usr_sr <= USER_CODE[ID_W-1:0];
        default: ;
      endcase
    end else if (state == SH_DR) begin
      case (dsel)
        D_BYP:   byp_q  <= tdi;
        D_ID:    id_sr  <= {tdi, id_sr[ID_W-1:1]};
        D_USR:   usr_sr <= {tdi, usr_sr[ID_W-1:1]};
        D_ADR:   adr_sr <= {tdi, adr_sr[ADDR_W-1:1]};
        D_COL:   col_sr <= {tdi, col_sr[COL_W-1:1]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dsel)
      D_BSR:   dr_lsb = bsr_so;
      D_ID:    dr_lsb = id_sr[0];
      D_USR:   dr_lsb = usr_sr[0];
      D_ADR:   dr_lsb = adr_sr[0];
      D_COL:   dr_lsb = col_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= (state == SH_IR) ? ir_sr[0] : dr_lsb;
      tdo_en_q <= (state == SH_IR) || (state == SH_DR);
    end
  end

  assign tdo         = tdo_q;
  assign tdo_en      = tdo_en_q;
  assign bsr_capture = (dsel == D_BSR) && (state == CAP_DR);
  assign bsr_shift   = (dsel == D_BSR) && (state == SH_DR);
  assign bsr_update  = (dsel == D_BSR) && (state == UP_DR);
  assign bsr_drive   = (ir == C_EXTEST) || (ir == C_CLAMP);
  assign pins_hiz    = (ir == C_HIZ);
  assign user_rst    = urst_q;
  assign nv_strobe   = is_nv && (state == RTI);
  assign nv_code     = ir;

  a_r11_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == SH_IR || state == SH_DR));
  a_r1_reset_to_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TLR) |=> (ir == C_IDC));
  a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (state == CAP_IR) |=> (ir_sr == C_CAPIR));
  a_r3_msb_is_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    ir[IR_W-1] |-> (!bsr_drive && !pins_hiz && !bsr_shift && !nv_strobe));
  a_r8_single_pulse: assert property (@(posedge tck) disable iff (!trst_n)
    user_rst |=> !user_rst);
  a_r8_pulse_after_update: assert property (@(posedge tck) disable iff (!trst_n)
    user_rst |-> $past(state == UP_IR));
  a_r6_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

endmodule

// File: tb/jtag_tap_decode_bench.sv
module jtag_tap_decode_bench;
  localparam int PERIOD = 20;
  localparam logic [31:0] IDV = 32'h1A5C_0043;
  localparam logic [31:0] UCV = 32'h8D31_F2A6;
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic bsr_so;
  logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_drive, pins_hiz, user_rst, nv_strobe;
  logic [7:0] nv_code;
  int checks = 0, errors = 0;

  assign bsr_so = ~tdi;

  jtag_tap_decode #(.ID_CODE(IDV), .USER_CODE(UCV)) u_jtag_tap_decode (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_drive(bsr_drive), .pins_hiz(pins_hiz),
    .user_rst(user_rst), .nv_strobe(nv_strobe), .nv_code(nv_code));

  always #(PERIOD/2) tck = ~tck;

  int m_st; logic [7:0] m_ir, m_irsh; logic m_byp, m_urst;
  logic [31:0] m_id, m_usr; logic [9:0] m_adr; logic [88:0] m_col;
  logic last_tdo = 0;

  function automatic int nxt(int s, logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;   S_RTI: return t ? S_SDR : S_RTI;
      S_SDR: return t ? S_SIR : S_CDR;   S_CDR: return t ? S_E1DR : S_SHDR;
      S_SHDR: return t ? S_E1DR : S_SHDR; S_E1DR: return t ? S_UDR : S_PDR;
      S_PDR: return t ? S_E2DR : S_PDR;  S_E2DR: return t ? S_UDR : S_SHDR;
      S_UDR: return t ? S_SDR : S_RTI;   S_SIR: return t ? S_TLR : S_CIR;
      S_CIR: return t ? S_E1IR : S_SHIR; S_SHIR: return t ? S_E1IR : S_SHIR;
      S_E1IR: return t ? S_UIR : S_PIR;  S_PIR: return t ? S_E2IR : S_PIR;
      S_E2IR: return t ? S_UIR : S_SHIR; default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic bit nv_op(logic [7:0] c);
    return c inside {8'h03, 8'h07, 8'h09, 8'h0A, 8'h14, 8'h15, 8'h1A, 8'h1E,
                     8'h24, 8'h27, 8'h2A, 8'h2F};
  endfunction

  // 0 bypass, 1 boundary, 2 id, 3 user, 4 address, 5 column
  function automatic int sel_of(logic [7:0] c);
    if (c[7]) return 0;
    case (c)
      8'h00, 8'h1C: return 1;  8'h16: return 2;  8'h17: return 3;
      8'h01: return 4;         8'h02: return 5;  default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] c);
    if (c[7]) return "R3";
    case (c)
      8'h16: return "R1 R4"; 8'h17: return "R4"; 8'h01, 8'h02: return "R5";
      8'h00, 8'h1C, 8'h20: return "R6"; 8'h18: return "R7"; 8'h22: return "R8";
      default: return nv_op(c) ? "R9" : "R10";
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_st = S_TLR; m_ir = 8'h16; m_irsh = 0; m_urst = 0; m_byp = 0;
      m_id = 0; m_usr = 0; m_adr = 0; m_col = 0;
    end else begin
      m_urst = (m_st == S_UIR) && (m_irsh == 8'h22);
      case (m_st)
        S_TLR: m_ir = 8'h16;
        S_CIR: m_irsh = 8'h01;
        S_SHIR: m_irsh = {tdi, m_irsh[7:1]};
        S_UIR: m_ir = m_irsh;
        S_CDR: case (sel_of(m_ir))
                 0: m_byp = 0; 2: m_id = IDV; 3: m_usr = UCV; default: ;
               endcase
        S_SHDR: case (sel_of(m_ir))
                 0: m_byp = tdi; 2: m_id = {tdi, m_id[31:1]}; 3: m_usr = {tdi, m_usr[31:1]};
                 4: m_adr = {tdi, m_adr[9:1]}; 5: m_col = {tdi, m_col[88:1]}; default: ;
               endcase
        default: ;
      endcase
      m_st = nxt(m_st, tms);
    end
  end

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge tck) begin
    #(PERIOD/4);
    begin
      logic en, bit_e; int s;
      s = sel_of(m_ir);
      en = (m_st == S_SHIR) || (m_st == S_SHDR);
      chk(tdo_en, en, "R11", "tdo_en");
      if (en) begin
        if (m_st == S_SHIR) chk(tdo, m_irsh[0], "R2", "tdo in Shift-IR");
        else begin
          case (s)
            1: bit_e = bsr_so; 2: bit_e = m_id[0]; 3: bit_e = m_usr[0];
            4: bit_e = m_adr[0]; 5: bit_e = m_col[0]; default: bit_e = m_byp;
          endcase
          chk(tdo, bit_e, tag_of(m_ir), "tdo in Shift-DR");
        end
      end
      chk(pins_hiz, m_ir == 8'h18, "R7", "pins_hiz");
      chk(bsr_drive, m_ir == 8'h00 || m_ir == 8'h20, "R6", "bsr_drive");
      chk(bsr_capture, s == 1 && m_st == S_CDR, "R6", "bsr_capture");
      chk(bsr_shift, s == 1 && m_st == S_SHDR, "R6", "bsr_shift");
      chk(bsr_update, s == 1 && m_st == S_UDR, "R6", "bsr_update");
      chk(user_rst, m_urst, "R8", "user_rst");
      chk(nv_strobe, nv_op(m_ir) && m_st == S_RTI, "R9", "nv_strobe");
      checks++;
      if (nv_code !== m_ir) begin
        errors++;
        $display("FAIL R9 nv_code: actual=%h expected=%h", nv_code, m_ir);
      end
      last_tdo = tdo;
    end
  end

  always @(posedge tck) begin
    #1;
    if (trst_n) chk(tdo, last_tdo, "R11", "tdo moved on rising edge");
  end

  task automatic clk(logic t, logic d);
    tms = t; tdi = d;
    @(posedge tck); #(PERIOD/4);
  endtask

  task automatic load_ir(logic [7:0] c);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < 8; i++) clk(i == 7, c[i]);
    clk(1, 0); clk(0, 0);
  endtask

  task automatic scan_dr(int n, logic [127:0] v);
    clk(1, 0); clk(0, 0); clk(0, 0);
    for (int i = 0; i < n; i++) clk(i == n - 1, v[i]);
    clk(1, 0); clk(0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) clk(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    errors++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge tck); #(PERIOD/4);
    idle(2);
    trst_n = 1;
    idle(2);
    scan_dr(32, 128'h5);                         // R1 identification after reset
    load_ir(8'h17); scan_dr(32, 128'h0F0F_3C3C);  // R4
    load_ir(8'h16); scan_dr(33, 128'h1_2345_6789);
    load_ir(8'h01); scan_dr(10, 128'h2B5); scan_dr(10, 128'h0F3); // R5
    load_ir(8'h02);
    scan_dr(89, {39'd0, 89'h1AB_CDEF_0123_4567_89AB_CDEF});
    scan_dr(89, {39'd0, 89'h0F0_F0F0_F0F0_F0F0_F0F0_F0F1});
    load_ir(8'h00); scan_dr(12, 128'hA5C);          // R6
    load_ir(8'h1C); scan_dr(7, 128'h35);
    load_ir(8'h20); scan_dr(3, 128'h5);
    load_ir(8'h18); scan_dr(4, 128'h9);             // R7
    load_ir(8'h22); idle(3);                         // R8
    load_ir(8'h18); load_ir(8'h22);                  // pin control held while next code shifts
    load_ir(8'h07); idle(4);                         // R9
    load_ir(8'h2F); idle(2);
    load_ir(8'h9F); scan_dr(6, 128'h2D);            // R3
    load_ir(8'hFF); scan_dr(3, 128'h3);
    load_ir(8'h3B); scan_dr(5, 128'h11);            // R10
    load_ir(8'h30); scan_dr(2, 128'h2);
    load_ir(8'h18);
    for (int i = 0; i < 5; i++) clk(1, 0);          // R1 reset by TMS
    clk(0, 0); scan_dr(32, 128'h0);
    load_ir(8'h01); scan_dr(10, 128'h155);
    clk(1, 0); clk(0, 0); clk(0, 0);                // Shift-DR then pause path
    for (int i = 0; i < 4; i++) clk(0, i[0]);
    clk(1, 1); clk(0, 0); clk(1, 0); clk(0, 1); clk(1, 0); clk(1, 0); clk(0, 0);
    load_ir(8'h00);
    trst_n = 0; idle(2); trst_n = 1; idle(1);      // R1 asynchronous reset
    scan_dr(32, 128'h0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule